// File: doc/BRIEF.md
# PLL Lock Monitor with Feedback Watchdog

This block produces a lock status flag for a phase-locked loop by watching the loop's reference clock and the returned feedback clock with a fast sampling clock. Both clocks are first brought into the sampling domain, where their rising edges are found. Each feedback cycle is then graded as clean or as a phase error. The grade depends on how many sampling ticks separate the latest reference rising edge from the feedback rising edge, compared with a programmable window.

The flag has asymmetric hysteresis. It needs a long unbroken run of clean feedback cycles before it rises. Once high, it falls after a short unbroken run of error cycles. If the feedback clock stops, no cycles are graded at all, so a watchdog takes over. The watchdog is clocked by a divided-down count of reference edges and is restarted by every feedback edge. When the PLL is bypassed, the flag pin carries a test-mode observation signal in place of the lock status, and the lock logic keeps running underneath.

Top module: `pll_lock_monitor`

## Requirements
- R1: While the block reset is held and right after it, `lock_o` is low and both run counters are clear.
- R2: A feedback cycle is graded when its rising edge is seen. The gap is the number of sampling ticks since the last reference rising edge, and it is 0 when both edges are seen on the same tick. The cycle is a phase error when the gap is greater than `WIN_TICKS` (default 2). A gap equal to `WIN_TICKS` is clean.
- R3: While unlocked, `CLEAN_RISE` (default 32) consecutive clean cycles set the flag high. After `CLEAN_RISE`-1 clean cycles it is still low.
- R4: While locked, `ERR_DROP` (default 4) consecutive error cycles clear the flag. After `ERR_DROP`-1 error cycles it is still high.
- R5: A clean cycle restarts the error run, and an error cycle restarts the clean run.
- R6: The watchdog counts ticks, one tick for every `REF_DIV` (default 4) reference rising edges. Each feedback rising edge restarts it. When it reaches `WD_LIMIT` (default 8) ticks without a feedback edge, the flag is cleared.
- R7: With `bypass_i` high, `lock_o` equals `test_obs_i` in the same cycle. With `bypass_i` low, `lock_o` shows the lock state, which kept updating while bypassed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk_i` |
| fb_clk_i | input | 1 | Feedback clock, asynchronous to `clk_i` |
| bypass_i | input | 1 | High when the PLL is bypassed; selects test observation |
| test_obs_i | input | 1 | Test-mode observation bit shown on `lock_o` during bypass |
| lock_o | output | 1 | Lock flag, or test observation while bypassed |

## Verification
A feedback rising edge that is first seen high at a sampling edge moves `lock_o` on the fourth sampling edge from there. That is two synchronizer stages, one grading register and one lock register. The bench drives both clocks at falling edges of the sampling clock in 16-tick periods, and keeps every feedback edge at tick 7 or earlier. It compares `lock_o` only at the end of each period, well after that four-edge delay. Watchdog expiry depends on the phase of the reference divider, so expiry lands between 29 and 32 reference edges after the last feedback edge. The bench checks the flag after 28 edges and again after 33. The bypass path has no register, so it is checked in the same cycle as the stimulus.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  // grading result of one feedback cycle
  typedef struct packed {
    logic valid;
    logic err;
  } grade_t;
endpackage

// File: rtl/lk_edge_sync.sv
module lk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/lk_phase_grade.sv
module lk_phase_grade
  import pll_lock_pkg::*;
#(
  parameter int WIN_TICKS = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ref_rise_i,
  input  logic   fb_rise_i,
  output grade_t grade_o
);
  localparam int GAP_MAX = WIN_TICKS + 1;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(GAP_MAX);
  localparam logic [GAP_W-1:0] GAP_WIN = GAP_W'(WIN_TICKS);

  logic [GAP_W-1:0] gap_q, gap_d, gap_now;
  grade_t           grade_q, grade_d;

  // ticks since last reference edge, saturating just past the window
  always_comb begin
    gap_now = ref_rise_i ? '0 : gap_q;
    if (ref_rise_i)          gap_d = GAP_W'(1);
    else if (gap_q != GAP_SAT) gap_d = gap_q + 1'b1;
    else                     gap_d = gap_q;
    grade_d.valid = fb_rise_i;
    grade_d.err   = fb_rise_i && (gap_now > GAP_WIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= GAP_SAT;
      grade_q <= '0;
    end else begin
      gap_q   <= gap_d;
      grade_q <= grade_d;
    end
  end

  assign grade_o = grade_q;

  a_r2_grade_after_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grade_q.valid |-> $past(fb_rise_i));
  a_r2_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_SAT);
endmodule

// File: rtl/lk_hysteresis.sv
module lk_hysteresis
  import pll_lock_pkg::*;
#(
  parameter int ERR_DROP   = 4,
  parameter int CLEAN_RISE = 32
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  grade_t grade_i,
  input  logic   wd_expire_i,
  output logic   lock_o
);
  localparam int ERR_W = $clog2(ERR_DROP + 1);
  localparam int CLN_W = $clog2(CLEAN_RISE + 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_DROP - 1);
  localparam logic [CLN_W-1:0] CLN_LAST = CLN_W'(CLEAN_RISE - 1);

  logic             lock_q, lock_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [CLN_W-1:0] cln_q, cln_d;

  always_comb begin
    lock_d = lock_q;
    err_d  = err_q;
    cln_d  = cln_q;
    if (wd_expire_i) begin
      lock_d = 1'b0;
      err_d  = '0;
      cln_d  = '0;
    end else if (grade_i.valid) begin
      if (grade_i.err) begin
        cln_d = '0;
        if (!lock_q)              err_d = '0;
        else if (err_q == ERR_LAST) begin
          lock_d = 1'b0;
          err_d  = '0;
        end else                  err_d = err_q + 1'b1;
      end else begin
        err_d = '0;
        if (lock_q)               cln_d = '0;
        else if (cln_q == CLN_LAST) begin
          lock_d = 1'b1;
          cln_d  = '0;
        end else                  cln_d = cln_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      err_q  <= '0;
      cln_q  <= '0;
    end else begin
      lock_q <= lock_d;
      err_q  <= err_d;
      cln_q  <= cln_d;
    end
  end

  assign lock_o = lock_q;

  a_r3_rise_on_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(grade_i.valid && !grade_i.err && !wd_expire_i));
  a_r4_fall_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past((grade_i.valid && grade_i.err) || wd_expire_i));
  a_r5_runs_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q <= ERR_LAST) && (cln_q <= CLN_LAST));
  a_r6_expire_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire_i |=> !lock_q);
endmodule

// File: rtl/lk_watchdog.sv
module lk_watchdog #(
  parameter int REF_DIV  = 4,
  parameter int WD_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  output logic expire_o
);
  localparam int DIV_W = $clog2(REF_DIV + 1);
  localparam int WD_W  = $clog2(WD_LIMIT + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);
  localparam logic [WD_W-1:0]  WD_TOP   = WD_W'(WD_LIMIT);
  localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(WD_LIMIT - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [WD_W-1:0]  wd_q, wd_d;
  logic             tick;

  always_comb begin
    tick  = ref_rise_i && (div_q == DIV_LAST);
    div_d = div_q;
    if (ref_rise_i) div_d = tick ? '0 : div_q + 1'b1;
    wd_d = wd_q;
    if (fb_rise_i)                  wd_d = '0;
    else if (tick && wd_q != WD_TOP) wd_d = wd_q + 1'b1;
    expire_o = tick && !fb_rise_i && (wd_q == WD_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      wd_q  <= '0;
    end else begin
      div_q <= div_d;
      wd_q  <= wd_d;
    end
  end

  a_r6_fb_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rise_i |=> (wd_q == '0));
  a_r6_wd_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q <= WD_TOP);
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_TICKS   = 2,
  parameter int ERR_DROP    = 4,
  parameter int CLEAN_RISE  = 32,
  parameter int REF_DIV     = 4,
  parameter int WD_LIMIT    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic fb_clk_i,
  input  logic bypass_i,
  input  logic test_obs_i,
  output logic lock_o
);
  localparam int NCLK = 2;

  logic [1:0]      rst_sync_q;
  logic            rst_n;
  logic [NCLK-1:0] clk_in, clk_rise;
  grade_t          grade;
  logic            wd_expire;
  logic            lock_state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign clk_in = {fb_clk_i, ref_clk_i};

  for (genvar g = 0; g < NCLK; g++) begin : g_sync
    lk_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .async_i(clk_in[g]),
      .rise_o (clk_rise[g])
    );
  end

  lk_phase_grade #(.WIN_TICKS(WIN_TICKS)) i_grade (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ref_rise_i(clk_rise[0]),
    .fb_rise_i (clk_rise[1]),
    .grade_o   (grade)
  );

  lk_watchdog #(.REF_DIV(REF_DIV), .WD_LIMIT(WD_LIMIT)) i_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ref_rise_i(clk_rise[0]),
    .fb_rise_i (clk_rise[1]),
    .expire_o  (wd_expire)
  );

  lk_hysteresis #(.ERR_DROP(ERR_DROP), .CLEAN_RISE(CLEAN_RISE)) i_hyst (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .grade_i    (grade),
    .wd_expire_i(wd_expire),
    .lock_o     (lock_state)
  );

  assign lock_o = bypass_i ? test_obs_i : lock_state;

  a_r1_low_in_reset: assert property (@(posedge clk_i)
    (!rst_n && !bypass_i) |-> !lock_o);
endmodule

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;
  localparam int WIN = 2;
  localparam int DROP = 4;
  localparam int RISE = 32;

  logic clk = 1'b0;
  logic rst_ni, ref_clk, fb_clk, bypass, obs;
  logic lock_o;

  int total = 0;
  int bad = 0;
  bit exp_lk;
  int exp_er, exp_cl;

  always #2.5 clk = ~clk;

  pll_lock_monitor i_pll_lock_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
    .bypass_i(bypass), .test_obs_i(obs), .lock_o(lock_o)
  );

  function automatic bit is_err(int d);
    return d > WIN;
  endfunction

  task automatic chk(bit exp, string req);
    total++;
    if (lock_o !== exp) begin
      bad++;
      $display("FAIL %s lock_o=%0b expected=%0b at %0t", req, lock_o, exp, $time);
    end
  endtask

  task automatic model_step(bit err);
    if (err) begin
      exp_cl = 0;
      if (exp_lk) begin
        exp_er++;
        if (exp_er >= DROP) begin exp_lk = 0; exp_er = 0; end
      end
    end else begin
      exp_er = 0;
      if (!exp_lk) begin
        exp_cl++;
        if (exp_cl >= RISE) begin exp_lk = 1; exp_cl = 0; end
      end
    end
  endtask

  // one 16-tick reference period; feedback rises d ticks after reference
  task automatic period(int d, bit fb_on);
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      ref_clk = (t < 8);
      fb_clk  = fb_on && (t >= d) && (t < d + 8);
    end
    if (fb_on) model_step(is_err(d));
  endtask

  task automatic run(int n, int d);
    for (int k = 0; k < n; k++) period(d, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0; ref_clk = 0; fb_clk = 0; bypass = 0; obs = 0;
    exp_lk = 0; exp_er = 0; exp_cl = 0;
    repeat (4) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(1'b0, "R1 after reset");

    // R3 with gap at the window edge (R2 clean boundary)
    run(RISE - 1, WIN);
    chk(1'b0, "R3 one short of rise");
    run(1, WIN);
    chk(1'b1, "R3 rise after full clean run");
    // R4 with gap just past the window (R2 error boundary)
    run(DROP - 1, WIN + 1);
    chk(1'b1, "R4 one short of drop");
    run(1, 0);
    run(DROP - 1, WIN + 1);
    chk(1'b1, "R5 clean restarts error run");
    run(1, WIN + 1);
    chk(1'b0, "R4 drop after full error run");
    // R5 error restarts clean run
    run(20, 1);
    run(1, 7);
    run(RISE - 1, 1);
    chk(1'b0, "R5 error restarts clean run");
    run(1, 0);
    chk(1'b1, "R3 rise after restart");

    // R6 feedback stops
    for (int k = 0; k < 28; k++) period(0, 1'b0);
    chk(1'b1, "R6 still high before timeout");
    for (int k = 0; k < 5; k++) period(0, 1'b0);
    chk(1'b0, "R6 cleared by watchdog");
    exp_lk = 0; exp_er = 0; exp_cl = 0;

    // R7 bypass observation
    bypass = 1'b1; obs = 1'b1;
    #0.5;
    chk(1'b1, "R7 obs high in bypass");
    obs = 1'b0;
    #0.5;
    chk(1'b0, "R7 obs low in bypass");
    run(RISE, 1);
    chk(1'b0, "R7 flag hidden in bypass");
    @(negedge clk);
    bypass = 1'b0;
    #0.5;
    chk(1'b1, "R7 lock state kept updating");

    // constrained random bursts, R2 to R5
    for (int b = 0; b < 12; b++) begin
      int pct = (b % 2 == 0) ? 3 : 50;
      for (int k = 0; k < 40; k++) begin
        int d;
        if (($urandom % 100) < pct) d = WIN + 1 + ($urandom % (8 - WIN - 1));
        else                        d = $urandom % (WIN + 1);
        period(d, 1'b1);
        chk(exp_lk, "R2 R3 R4 R5 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule